// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-ported static memory. Every control and address input is sampled on the rising clock edge, and read data leaves through an output register. Each clock edge the block decodes one cycle, which is one of: idle, deselect, burst start, burst advance or burst suspend. It uses one of three addresses: the external address, the current burst address plus one inside an aligned group of four, or the current burst address unchanged.

A burst can begin from either of two address strobes. The processor strobe always begins a read. The controller strobe begins a read or a write, chosen by the write qualifiers: a global write, a byte-write enable and one enable per byte lane. While a burst is active and no strobe is present, the advance input picks between stepping the address and holding it. Holding the address is how wait states are inserted.

Bus drive is reported on a drive-enable output instead of a bidirectional pin. The output-enable and sleep inputs gate it at once, without waiting for a clock edge. The array is built from one register file per byte lane. Each lane holds eight data bits and, optionally, one parity bit.

Top module: `burst_sram`

## Requirements
- R1: While rst_n is low and after it is released, dout_en is low. The burst is inactive, so advance and suspend cycles neither read nor write until a strobe starts a burst.
- R2: The chip is selected when chip_sel_n is low, chip_sel2_n is low and chip_sel2 is high. In that state, cpu_stb_n low at edge k starts a read at addr, whatever the write qualifiers are. The data is on dout with dout_en high after edge k+1.
- R3: When ctl_stb_n is low with cpu_stb_n not accepted and the chip selected, a burst starts at addr. It is a write if all_wr_n is low, or if lane_wr_en_n is low and any lane_sel_n bit is low. With all of them high it is a read.
- R4: Lane i is din/dout bits [9i+8:9i], and bit 9i+8 is that lane's parity bit. With lane_wr_en_n low, only lanes whose lane_sel_n bit is low are written. With all_wr_n low, every lane is written whatever lane_sel_n holds.
- R5: With no strobe and an active burst, step_n low uses the next address. The low two bits add one modulo 4 (3 wraps to 0) and the upper bits stay fixed. The cycle reads or writes according to the qualifiers.
- R6: With no strobe and an active burst, step_n high repeats the current address for a read or a write.
- R7: A strobe seen while the chip is not selected is a deselect cycle. dout_en is low after the next edge, and later advance or suspend cycles do nothing until a new start.
- R8: cpu_stb_n is ignored while chip_sel_n is high. ctl_stb_n then decides between start and deselect, and with neither strobe the burst continues.
- R9: drv_en_n high or sleep high forces dout_en low in the same instant, without a clock edge. Data that is pending reappears when both are released.
- R10: Cycles with sleep high neither write, nor start, nor move the burst address.
- R11: A read sees every write captured at an earlier edge. Data from a read is not altered by a write to the same word in the following cycle.
- R12: Every write cycle is issued with the bus undriven: dout_en is low at the edge that captures write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | External word address |
| chip_sel_n | input | 1 | Primary chip select, active low; also qualifies cpu_stb_n |
| chip_sel2_n | input | 1 | Secondary chip select, active low |
| chip_sel2 | input | 1 | Secondary chip select, active high |
| cpu_stb_n | input | 1 | Processor address strobe, read-only start |
| ctl_stb_n | input | 1 | Controller address strobe, read or write start |
| step_n | input | 1 | Burst advance, low steps, high holds |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_en_n | input | 1 | Byte-write enable |
| lane_sel_n | input | LANES | Per-lane write enables, active low |
| din | input | LANES*(LANE_BITS+PARITY) | Write data |
| drv_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down |
| dout | output | LANES*(LANE_BITS+PARITY) | Registered read data |
| dout_en | output | 1 | Bus drive enable |

## Verification
The bus-clearance property assumes that the driver of the inputs sets drv_en_n high for every write cycle that follows a read. The stimulus does this in each of its write helpers. The read-latency and deselect properties take the chip selects and strobes to be stable across the edge at which they are sampled. The bench changes inputs only one nanosecond after an edge, and changes drv_en_n and sleep between edges only in the asynchronous gating checks.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE,
      CYC_DESEL,
      CYC_START,
      CYC_NEXT,
      CYC_HOLD
   } cyc_kind_t;
endpackage

// File: rtl/bsram_cycle_decode.sv
module bsram_cycle_decode
   import bsram_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             chip_sel_n,
   input  logic             chip_sel2_n,
   input  logic             chip_sel2,
   input  logic             cpu_stb_n,
   input  logic             ctl_stb_n,
   input  logic             step_n,
   input  logic             sleep,
   input  logic             active,
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   output cyc_kind_t        kind,
   output logic             wr,
   output logic             rd,
   output logic [LANES-1:0] lane_we
);
   logic             chip_on;
   logic             cpu_hit;
   logic             force_rd;
   logic             xfer;
   logic [LANES-1:0] qual_lanes;

   assign chip_on = !chip_sel_n && !chip_sel2_n && chip_sel2;
   assign cpu_hit = !chip_sel_n && !cpu_stb_n;

   for (genvar i = 0; i < LANES; i++) begin : g_qual
      assign qual_lanes[i] = !all_wr_n || (!lane_wr_en_n && !lane_sel_n[i]);
   end

   always_comb begin
      kind     = CYC_IDLE;
      force_rd = 1'b0;
      if (sleep) begin
         kind = CYC_IDLE;
      end else if (cpu_hit) begin
         kind     = chip_on ? CYC_START : CYC_DESEL;
         force_rd = 1'b1;
      end else if (!ctl_stb_n) begin
         kind = chip_on ? CYC_START : CYC_DESEL;
      end else if (active) begin
         kind = step_n ? CYC_HOLD : CYC_NEXT;
      end
   end

   assign xfer    = (kind == CYC_START) || (kind == CYC_NEXT) || (kind == CYC_HOLD);
   assign wr      = xfer && !force_rd && (|qual_lanes);
   assign rd      = xfer && !wr;
   assign lane_we = wr ? qual_lanes : '0;
endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_kind_t         kind,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              active
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  cur_q;
   logic               act_q;
   logic [BURST_W-1:0] step_lo;
   logic [HI_W-1:0]    group_hi;

   assign step_lo  = cur_q[BURST_W-1:0] + 1'b1;
   assign group_hi = cur_q[ADDR_W-1:BURST_W];

   always_comb begin
      case (kind)
         CYC_START: eff_addr = ext_addr;
         CYC_NEXT:  eff_addr = {group_hi, step_lo};
         default:   eff_addr = cur_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         act_q <= 1'b0;
      end else begin
         case (kind)
            CYC_START: begin
               cur_q <= eff_addr;
               act_q <= 1'b1;
            end
            CYC_DESEL: act_q <= 1'b0;
            CYC_NEXT, CYC_HOLD: cur_q <= eff_addr;
            default: ;
         endcase
      end
   end

   assign cur_addr = cur_q;
   assign active   = act_q;
endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    rd_req,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] q,
   output logic                    q_vld
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [ADDR_W-1:0] rd_addr_q;
   logic              rd_pend_q;
   logic              vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         vld_q     <= 1'b0;
      end else begin
         rd_pend_q <= rd_req;
         vld_q     <= rd_pend_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_req) rd_addr_q <= rd_addr;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] q_r;

      always_ff @(posedge clk) begin
         if (lane_we[i]) store[wr_addr] <= wr_data[i*LANE_W +: LANE_W];
         if (rd_pend_q)  q_r <= store[rd_addr_q];
      end

      assign q[i*LANE_W +: LANE_W] = q_r;
   end

   assign q_vld = vld_q;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import bsram_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 2,
   parameter int LANE_BITS = 8,
   parameter int PARITY    = 1,
   parameter int BURST_W   = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic                                  chip_sel_n,
   input  logic                                  chip_sel2_n,
   input  logic                                  chip_sel2,
   input  logic                                  cpu_stb_n,
   input  logic                                  ctl_stb_n,
   input  logic                                  step_n,
   input  logic                                  all_wr_n,
   input  logic                                  lane_wr_en_n,
   input  logic [LANES-1:0]                      lane_sel_n,
   input  logic [LANES*(LANE_BITS+PARITY)-1:0]   din,
   input  logic                                  drv_en_n,
   input  logic                                  sleep,
   output logic [LANES*(LANE_BITS+PARITY)-1:0]   dout,
   output logic                                  dout_en
);
   localparam int LANE_W = LANE_BITS + PARITY;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("burst_sram: ADDR_W must exceed BURST_W");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("burst_sram: BURST_W must be at least 1");
   end
   if (LANES < 1 || LANE_BITS < 1) begin : g_bad_lane
      $error("burst_sram: LANES and LANE_BITS must be positive");
   end
   if (PARITY != 0 && PARITY != 1) begin : g_bad_par
      $error("burst_sram: PARITY must be 0 or 1");
   end

   cyc_kind_t         cyc_kind;
   logic              cyc_wr;
   logic              cyc_rd;
   logic [LANES-1:0]  lane_we;
   logic              burst_active;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic              q_vld;

   bsram_cycle_decode #(.LANES(LANES)) u_decode (
      .chip_sel_n   (chip_sel_n),
      .chip_sel2_n  (chip_sel2_n),
      .chip_sel2    (chip_sel2),
      .cpu_stb_n    (cpu_stb_n),
      .ctl_stb_n    (ctl_stb_n),
      .step_n       (step_n),
      .sleep        (sleep),
      .active       (burst_active),
      .all_wr_n     (all_wr_n),
      .lane_wr_en_n (lane_wr_en_n),
      .lane_sel_n   (lane_sel_n),
      .kind         (cyc_kind),
      .wr           (cyc_wr),
      .rd           (cyc_rd),
      .lane_we      (lane_we)
   );

   bsram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (cyc_kind),
      .ext_addr (addr),
      .eff_addr (eff_addr),
      .cur_addr (cur_addr),
      .active   (burst_active)
   );

   bsram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .wr_addr (eff_addr),
      .wr_data (din),
      .rd_req  (cyc_rd),
      .rd_addr (eff_addr),
      .q       (dout),
      .q_vld   (q_vld)
   );

   assign dout_en = q_vld && !drv_en_n && !sleep;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_sel_n,
   input logic              chip_sel2_n,
   input logic              chip_sel2,
   input logic              cpu_stb_n,
   input logic              ctl_stb_n,
   input logic              drv_en_n,
   input logic              sleep,
   input logic              dout_en,
   input cyc_kind_t         kind,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              wr
);
   logic sel_ok;
   logic strobe_seen;
   assign sel_ok      = !chip_sel_n && !chip_sel2_n && chip_sel2;
   assign strobe_seen = (!chip_sel_n && !cpu_stb_n) || !ctl_stb_n;

   AST_CPU_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && sel_ok && !cpu_stb_n) |-> ##2 (dout_en || drv_en_n || sleep)); // R2

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && strobe_seen && !sel_ok) |-> ##2 !dout_en); // R7

   AST_NEXT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CYC_NEXT) |=>
         (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)) &&
         (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))); // R5

   AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CYC_HOLD) |=> $stable(cur_addr)); // R6

   AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(cur_addr)); // R10

   AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !wr); // R10

   AST_BUS_FREE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !dout_en); // R12
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chip_sel_n  (chip_sel_n),
   .chip_sel2_n (chip_sel2_n),
   .chip_sel2   (chip_sel2),
   .cpu_stb_n   (cpu_stb_n),
   .ctl_stb_n   (ctl_stb_n),
   .drv_en_n    (drv_en_n),
   .sleep       (sleep),
   .dout_en     (dout_en),
   .kind        (cyc_kind),
   .cur_addr    (cur_addr),
   .wr          (cyc_wr)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
   localparam int AW = 6;
   localparam int NW = 1 << AW;
   localparam int DW = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          sel_n, sel2_n, sel2, cpu_n, ctl_n, step_n, allw_n, lwe_n, drv_n, sleep;
   logic [1:0]    lsel_n;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #2.5 clk = ~clk;

   burst_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .chip_sel_n(sel_n), .chip_sel2_n(sel2_n), .chip_sel2(sel2),
      .cpu_stb_n(cpu_n), .ctl_stb_n(ctl_n), .step_n(step_n),
      .all_wr_n(allw_n), .lane_wr_en_n(lwe_n), .lane_sel_n(lsel_n),
      .din(din), .drv_en_n(drv_n), .sleep(sleep),
      .dout(dout), .dout_en(dout_en)
   );

   int nchecks = 0;
   int nfail   = 0;
   string cur_req = "R1";

   logic [DW-1:0] m_mem [NW];
   logic          m_act, m_pend_v, m_out_v;
   logic [AW-1:0] m_cur, m_pend_a;
   logic [DW-1:0] m_out_d;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int s);
      return DW'((a * 1031 + s * 7919) ^ (a << 11) ^ (s << 4));
   endfunction

   task automatic defaults();
      sel_n = 0; sel2_n = 0; sel2 = 1; cpu_n = 1; ctl_n = 1; step_n = 1;
      allw_n = 1; lwe_n = 1; lsel_n = 2'b11; drv_n = 0; sleep = 0;
   endtask

   // one clock: model the edge from the requirements, then check the outputs
   task automatic step();
      logic chip_on, cpu_hit, frc, wr, n_v;
      logic [1:0] ql;
      logic [AW-1:0] ea;
      logic [DW-1:0] n_d;
      int kind;
      @(posedge clk);
      n_v = m_pend_v;
      n_d = m_mem[m_pend_a];
      chip_on = !sel_n && !sel2_n && sel2;
      cpu_hit = !sel_n && !cpu_n;
      frc = 0; kind = 0;
      if (sleep) kind = 0;
      else if (cpu_hit) begin kind = chip_on ? 2 : 1; frc = 1; end
      else if (!ctl_n) kind = chip_on ? 2 : 1;
      else if (m_act) kind = step_n ? 4 : 3;
      for (int i = 0; i < 2; i++) ql[i] = !allw_n || (!lwe_n && !lsel_n[i]);
      wr = (kind >= 2) && !frc && (ql != 0);
      if (kind == 2) ea = addr;
      else if (kind == 3) ea = {m_cur[AW-1:2], 2'(m_cur[1:0] + 2'd1)};
      else ea = m_cur;
      if (wr) for (int i = 0; i < 2; i++) if (ql[i]) m_mem[ea][9*i +: 9] = din[9*i +: 9];
      m_pend_v = (kind >= 2) && !wr;
      if (m_pend_v) m_pend_a = ea;
      if (kind == 2) m_act = 1;
      if (kind == 1) m_act = 0;
      if (kind >= 2) m_cur = ea;
      m_out_v = n_v;
      if (n_v) m_out_d = n_d;
      #1;
      begin
         logic exp_en;
         exp_en = m_out_v && !drv_n && !sleep;
         chk(dout_en === exp_en, cur_req, {17'd0, dout_en}, {17'd0, exp_en});
         if (exp_en) chk(dout === m_out_d, cur_req, dout, m_out_d);
      end
   endtask

   task automatic bus_free_check();
      #0.5;
      chk(dout_en === 1'b0, "R12", {17'd0, dout_en}, 18'd0);
   endtask

   task automatic rd_start(input int a);
      defaults(); cpu_n = 0; addr = AW'(a);
      allw_n = 0; drv_n = 0; // qualifiers must not matter (R2)
      step();
   endtask

   task automatic wr_start(input int a, input logic [DW-1:0] d);
      defaults(); ctl_n = 0; allw_n = 0; drv_n = 1; addr = AW'(a); din = d;
      bus_free_check();
      step();
   endtask

   task automatic cont(input bit adv, input bit wr, input logic [DW-1:0] d);
      defaults(); step_n = !adv; din = d;
      if (wr) begin allw_n = 0; drv_n = 1; bus_free_check(); end
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchecks++; nfail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      defaults(); addr = '0; din = '0; rst_n = 0;
      m_act = 0; m_pend_v = 0; m_out_v = 0; m_cur = '0; m_pend_a = '0; m_out_d = '0;
      repeat (4) @(posedge clk);
      #1;
      cur_req = "R1";
      chk(dout_en === 1'b0, "R1", {17'd0, dout_en}, 18'd0);
      rst_n = 1;
      // continue cycles on an inactive burst do nothing
      cont(1, 0, '0); cont(0, 0, '0); cont(1, 0, '0);

      // R3: fill the array through the controller strobe, global write
      cur_req = "R3";
      for (int a = 0; a < NW; a++) wr_start(a, pat(a, 1));
      // R2: processor strobe reads back to back, global write held low
      cur_req = "R2";
      for (int a = 0; a < NW; a++) rd_start(a);
      cont(0, 0, '0); cont(0, 0, '0);

      // R5: burst from every start, wrap inside group of four
      cur_req = "R5";
      for (int a = 0; a < NW; a++) begin
         rd_start(a);
         for (int k = 0; k < 3; k++) cont(1, 0, '0);
      end
      wr_start(13, pat(13, 2));
      for (int k = 0; k < 4; k++) cont(1, 1, pat(k, 3));
      rd_start(12);
      for (int k = 0; k < 4; k++) cont(1, 0, '0);

      // R4 and R3: byte lane masks, including all lanes off (a read)
      for (int a = 20; a < 28; a++) begin
         for (int m = 0; m < 4; m++) begin
            cur_req = (m == 3) ? "R3" : "R4";
            defaults(); ctl_n = 0; lwe_n = 0; lsel_n = 2'(m); drv_n = (m != 3);
            addr = AW'(a); din = pat(a, 10 + m);
            if (m != 3) bus_free_check();
            step();
            cur_req = "R4";
            rd_start(a); cont(0, 0, '0); cont(0, 0, '0);
         end
         defaults(); ctl_n = 0; allw_n = 0; lwe_n = 0; lsel_n = 2'b11; drv_n = 1;
         addr = AW'(a); din = pat(a, 20);
         bus_free_check();
         step();
         rd_start(a); cont(0, 0, '0); cont(0, 0, '0);
      end

      // R6: suspend during read and write bursts
      cur_req = "R6";
      rd_start(33);
      cont(0, 0, '0); cont(0, 0, '0); cont(1, 0, '0); cont(0, 0, '0); cont(1, 0, '0);
      wr_start(41, pat(41, 30));
      cont(0, 1, pat(41, 31)); cont(1, 1, pat(42, 32)); cont(0, 1, pat(42, 33));
      rd_start(41); cont(1, 0, '0); cont(0, 0, '0); cont(0, 0, '0);

      // R8: processor strobe with primary select high
      cur_req = "R8";
      rd_start(50);
      defaults(); sel_n = 1; cpu_n = 0; step_n = 0; addr = AW'(7); step();
      cont(0, 0, '0);
      defaults(); sel_n = 1; cpu_n = 0; ctl_n = 0; addr = AW'(9); step();
      cont(1, 0, '0); cont(1, 0, '0);

      // R7: deselect, then continue writes must be dropped
      cur_req = "R7";
      rd_start(52);
      defaults(); ctl_n = 0; sel2 = 0; addr = AW'(60); step();
      cont(1, 1, pat(0, 40)); cont(0, 1, pat(0, 41)); cont(1, 0, '0);
      for (int a = 52; a < 56; a++) rd_start(a);
      cont(0, 0, '0); cont(0, 0, '0);

      // R10: sleep blocks writes and address motion
      cur_req = "R10";
      rd_start(44);
      defaults(); sleep = 1; #0.5;
      chk(dout_en === 1'b0, "R10", {17'd0, dout_en}, 18'd0);
      ctl_n = 0; allw_n = 0; drv_n = 1; addr = AW'(44); din = pat(44, 50); step();
      defaults(); sleep = 1; step_n = 0; step();
      cont(1, 0, '0); cont(0, 0, '0);
      rd_start(44); cont(0, 0, '0); cont(0, 0, '0);

      // R9: asynchronous gating by drv_en_n and sleep
      cur_req = "R9";
      rd_start(3); cont(0, 0, '0);
      drv_n = 1; #0.5;
      chk(dout_en === 1'b0, "R9", {17'd0, dout_en}, 18'd0);
      drv_n = 0; #0.5;
      chk(dout_en === 1'b1, "R9", {17'd0, dout_en}, 18'd1);
      chk(dout === m_out_d, "R9", dout, m_out_d);
      sleep = 1; #0.5;
      chk(dout_en === 1'b0, "R9", {17'd0, dout_en}, 18'd0);
      sleep = 0; #0.5;
      chk(dout_en === 1'b1, "R9", {17'd0, dout_en}, 18'd1);

      // R11: write then read at once; read then overwrite next cycle
      cur_req = "R11";
      for (int a = 0; a < 8; a++) begin
         wr_start(a, pat(a, 60));
         rd_start(a);
         wr_start(a, pat(a, 61));
         cont(0, 0, '0);
         rd_start(a); cont(0, 0, '0); cont(0, 0, '0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule